// File: doc/BRIEF.md
# Atomic Swap Unit for a Resident Cache Line

This block carries out atomic exchange operations on the bytes of one cache line that it holds in its own byte registers. A request names a byte offset into the line, an access size in bytes, the new data to store, an optional compare operand and a flag that makes the exchange conditional. In the cycle after a request strobe, the block returns the bytes that were at the offset before the operation. It also reports whether the line was written and whether the request was malformed. The updated line is visible at all times on a flat output.

An unconditional exchange always stores the new data. A conditional exchange stores it only when the current bytes equal the compare operand over the whole access size. A separate load port fills the line one 8-byte slot at a time, so a test harness or the surrounding cache can seed its contents. Tag lookup, coherence permission and the memory side are not part of this block.

Top module: `cas_unit`

## Requirements
- R1: After reset, `done`, `err` and `wrote` are 0, `old_data` is all zeros and every byte of the line is zero.
- R2: When `ld_en` is high and `req_valid` is low at a clock edge, byte k (k = 0..7) of `ld_word` (bits 8k+7:8k) is stored into line byte 8*`ld_slot`+k and is visible on `line_o` after that edge.
- R3: `done` is high in exactly the cycle that follows a cycle with `req_valid` high, and low otherwise.
- R4: For a legal request, `old_data` holds line bytes `req_off`..`req_off`+`req_size`-1 as they were before the operation, in little-endian order (line byte `req_off` in bits 7:0), with zeros above the access size, whether or not the line is written.
- R5: A legal unconditional request (`req_cond`=0) sets `wrote` to 1 and stores byte j of `req_swap` into line byte `req_off`+j for j < `req_size`; all other line bytes keep their values.
- R6: A legal conditional request (`req_cond`=1) writes the line exactly as in R5, and sets `wrote`, only when the old bytes equal the low `req_size` bytes of `req_cmp`; otherwise `wrote` is 0 and the line is unchanged.
- R7: For a 4-byte conditional request, bits 63:32 of `req_cmp` have no effect on the outcome.
- R8: `req_size` is a byte count. It is legal as 1, 2, 4 or 8 when unconditional and as 4 or 8 when conditional, and the offset must be a multiple of the size. An illegal request sets `err` for one cycle, returns all-zero `old_data`, leaves `wrote` at 0 and leaves the line unchanged.
- R9: A load presented in the same cycle as a request is ignored.
- R10: Line byte b appears on `line_o` bits 8b+7:8b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load one 8-byte slot of the line |
| ld_slot | input | $clog2(LINE_BYTES/8) | Slot index for the load |
| ld_word | input | 64 | Load data, little-endian |
| req_valid | input | 1 | Request strobe |
| req_cond | input | 1 | 1 = conditional exchange |
| req_off | input | $clog2(LINE_BYTES) | Byte offset in the line |
| req_size | input | 4 | Access size in bytes |
| req_swap | input | 64 | Data to store |
| req_cmp | input | 64 | Compare operand for conditional requests |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal request pulse |
| wrote | output | 1 | Line was written by the completed request |
| old_data | output | 64 | Pre-operation bytes returned to the requester |
| line_o | output | 8*LINE_BYTES | Current line contents |

## Verification
The bench sweeps every offset, every size code from 0 to 15 and both request kinds, each with a matching and a mismatching compare operand, against a byte-level model of the line. This catches a design that misjudges alignment or size legality, which would corrupt neighbouring bytes or miss the error pulse. It also catches one that compares only part of a 4-byte operand or includes its upper half, which would flip the write decision when junk sits in bits 63:32. The model exposes a design that returns post-write data or a byte-reversed word, because every returned value is checked against the line before the write. A load colliding with a request is used to show that the collision leaves the line untouched.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int CAS_MAX_BYTES = 8;
  localparam int CAS_DW        = 8 * CAS_MAX_BYTES;
  localparam int CAS_SZ_W      = $clog2(CAS_MAX_BYTES) + 1;

  // Size codes accepted for each request kind.
  function automatic logic size_legal(input logic [CAS_SZ_W-1:0] sz, input logic cond);
    if (cond) return (sz == 4'd4) || (sz == 4'd8);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction

  // Offset is a multiple of a power-of-two size.
  function automatic logic is_aligned(input logic [15:0] off, input logic [CAS_SZ_W-1:0] sz);
    logic [15:0] lowm;
    lowm = {12'd0, sz} - 16'd1;
    return (off & lowm) == 16'd0;
  endfunction

  // Bit mask covering the low sz bytes.
  function automatic logic [CAS_DW-1:0] size_bits(input logic [CAS_SZ_W-1:0] sz);
    logic [CAS_DW-1:0] m;
    for (int b = 0; b < CAS_MAX_BYTES; b++)
      m[8*b +: 8] = (CAS_SZ_W'(b) < sz) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/cas_check.sv
module cas_check
  import cas_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic [OFF_W-1:0]    off,
  input  logic [CAS_SZ_W-1:0] size,
  input  logic                cond,
  output logic                legal
);
  logic size_ok;
  logic align_ok;

  assign size_ok  = size_legal(size, cond);
  assign align_ok = is_aligned(16'(off), size);
  assign legal    = size_ok && align_ok;
endmodule

// File: rtl/cas_lane_sel.sv
module cas_lane_sel
  import cas_pkg::*;
#(
  parameter int LINE_BYTES = 16
) (
  input  logic [8*LINE_BYTES-1:0]      line,
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [CAS_SZ_W-1:0]           size,
  output logic [CAS_DW-1:0]             old
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar k = 0; k < CAS_MAX_BYTES; k++) begin : g_lane
    logic [OFF_W-1:0] idx;
    assign idx = off + OFF_W'(k);
    assign old[8*k +: 8] = (CAS_SZ_W'(k) < size) ? line[{idx, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/cas_line_store.sv
module cas_line_store
  import cas_pkg::*;
#(
  parameter int LINE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_en,
  input  logic [$clog2(LINE_BYTES/8)-1:0]   ld_slot,
  input  logic [CAS_DW-1:0]                 ld_word,
  input  logic                              hold,
  input  logic                              wr_en,
  input  logic [$clog2(LINE_BYTES)-1:0]     wr_off,
  input  logic [CAS_SZ_W-1:0]               wr_size,
  input  logic [CAS_DW-1:0]                 wr_data,
  output logic [8*LINE_BYTES-1:0]           line_q
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SLOT_W = $clog2(LINE_BYTES/8);

  logic load_take;
  assign load_take = ld_en && !hold;

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    logic [OFF_W-1:0] rel;
    logic             in_span;
    logic             ld_hit;
    logic [7:0]       byte_q;

    assign rel     = OFF_W'(i) - wr_off;
    assign in_span = (OFF_W'(i) >= wr_off) && (16'(rel) < 16'(wr_size));
    assign ld_hit  = load_take && (ld_slot == SLOT_W'(i / 8));

    always_ff @(posedge clk) begin
      if (!rst_n)                 byte_q <= 8'h00;
      else if (wr_en && in_span)  byte_q <= wr_data[{rel[2:0], 3'b000} +: 8];
      else if (ld_hit)            byte_q <= ld_word[8*(i % 8) +: 8];
    end

    assign line_q[8*i +: 8] = byte_q;
  end
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int LINE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_en,
  input  logic [$clog2(LINE_BYTES/8)-1:0]   ld_slot,
  input  logic [63:0]                       ld_word,
  input  logic                              req_valid,
  input  logic                              req_cond,
  input  logic [$clog2(LINE_BYTES)-1:0]     req_off,
  input  logic [3:0]                        req_size,
  input  logic [63:0]                       req_swap,
  input  logic [63:0]                       req_cmp,
  output logic                              done,
  output logic                              err,
  output logic                              wrote,
  output logic [63:0]                       old_data,
  output logic [8*LINE_BYTES-1:0]           line_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic              req_legal;
  logic [CAS_DW-1:0] old_sel;
  logic              cmp_hit;
  logic              do_write;
  logic              done_q, err_q, wrote_q;
  logic [CAS_DW-1:0] old_q;

  cas_check #(.OFF_W(OFF_W)) u_check (
    .off(req_off), .size(req_size), .cond(req_cond), .legal(req_legal)
  );

  cas_lane_sel #(.LINE_BYTES(LINE_BYTES)) u_sel (
    .line(line_o), .off(req_off), .size(req_size), .old(old_sel)
  );

  assign cmp_hit  = (old_sel == (req_cmp & size_bits(req_size)));
  assign do_write = req_valid && req_legal && (!req_cond || cmp_hit);

  cas_line_store #(.LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_slot(ld_slot), .ld_word(ld_word),
    .hold(req_valid),
    .wr_en(do_write), .wr_off(req_off), .wr_size(req_size), .wr_data(req_swap),
    .line_q(line_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wrote_q <= 1'b0;
      old_q   <= '0;
    end else begin
      done_q  <= req_valid;
      err_q   <= req_valid && !req_legal;
      wrote_q <= do_write;
      if (req_valid) old_q <= req_legal ? old_sel : '0;
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign wrote    = wrote_q;
  assign old_data = old_q;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done); // R3
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid)); // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (old_data == '0 && !wrote)); // R8
  AST_ERR_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(line_o)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, wrote})); // R8
  AST_NOWRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wrote) |-> $stable(line_o)); // R6
  AST_UNCOND_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !$past(req_cond)) |-> wrote); // R5
  AST_WROTE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wrote |-> done); // R3
endmodule

// File: tb/cas_unit_bench.sv
module cas_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LB = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_en;
  logic [0:0]   ld_slot;
  logic [63:0]  ld_word;
  logic         req_valid, req_cond;
  logic [3:0]   req_off;
  logic [3:0]   req_size;
  logic [63:0]  req_swap, req_cmp;
  logic         done, err, wrote;
  logic [63:0]  old_data;
  logic [127:0] line_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0]  mdl [LB];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_unit #(.LINE_BYTES(LB)) u_cas_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot), .ld_word(ld_word),
    .req_valid(req_valid), .req_cond(req_cond), .req_off(req_off), .req_size(req_size),
    .req_swap(req_swap), .req_cmp(req_cmp), .done(done), .err(err), .wrote(wrote),
    .old_data(old_data), .line_o(line_o)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [127:0] mdl_flat();
    logic [127:0] f;
    for (int b = 0; b < LB; b++) f[8*b +: 8] = mdl[b];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_slot(input int s, input logic [63:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_slot = 1'(s); ld_word = w;
    @(negedge clk);
    ld_en = 1'b0;
    for (int k = 0; k < 8; k++) mdl[8*s + k] = w[8*k +: 8];
  endtask

  task automatic do_req(input bit cond, input int off, input int size, input bit want_match);
    bit legal;
    logic [63:0] exp_old, bmask, cmpv, swapv;
    rng = next_rand(rng); swapv = rng;
    rng = next_rand(rng);
    legal = (size <= 8) && (size != 0) && ((off % (size == 0 ? 1 : size)) == 0) &&
            (cond ? (size == 4 || size == 8) : (size == 1 || size == 2 || size == 4 || size == 8));
    exp_old = '0; bmask = '0;
    for (int k = 0; k < 8; k++)
      if (k < size) begin
        bmask[8*k +: 8] = 8'hFF;
        exp_old[8*k +: 8] = mdl[(off + k) % LB];
      end
    // R7: junk above the access size; mismatch flips bit 0
    cmpv = (exp_old & bmask) | (rng & ~bmask);
    if (!want_match) cmpv = cmpv ^ 64'h1;
    @(negedge clk);
    req_valid = 1'b1; req_cond = cond; req_off = 4'(off); req_size = 4'(size);
    req_swap = swapv; req_cmp = cmpv;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 done pulse", 128'(done), 128'(1));
    chk("R8 err flag", 128'(err), 128'(!legal));
    chk("R4 old data", 128'(old_data), legal ? 128'(exp_old) : 128'(0));
    if (legal && (!cond || want_match))
      for (int k = 0; k < size; k++) mdl[off + k] = swapv[8*k +: 8];
    chk(cond ? "R6 wrote" : "R5 wrote", 128'(wrote), 128'(legal && (!cond || want_match)));
    chk(legal ? (cond ? "R6 line" : "R5 line") : "R8 line", line_o, mdl_flat());
    @(negedge clk);
    chk("R3 done low", 128'(done), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_slot = '0; ld_word = '0;
    req_valid = 1'b0; req_cond = 1'b0; req_off = '0; req_size = '0;
    req_swap = '0; req_cmp = '0;
    for (int b = 0; b < LB; b++) mdl[b] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 128'(done), 128'(0));
    chk("R1 err", 128'(err), 128'(0));
    chk("R1 wrote", 128'(wrote), 128'(0));
    chk("R1 old_data", 128'(old_data), 128'(0));
    chk("R1 line", line_o, 128'(0));
    rst_n = 1'b1;

    // R2 / R10 load layout
    load_slot(0, 64'h0706_0504_0302_0100);
    load_slot(1, 64'h0F0E_0D0C_0B0A_0908);
    chk("R10 line byte layout", line_o, 128'h0F0E0D0C0B0A09080706050403020100);
    chk("R2 load", line_o, mdl_flat());

    // R9 load with request in the same cycle
    @(negedge clk);
    ld_en = 1'b1; ld_slot = 1'b0; ld_word = 64'hDEAD_BEEF_DEAD_BEEF;
    req_valid = 1'b1; req_cond = 1'b1; req_off = 4'd0; req_size = 4'd8;
    req_swap = 64'h1111_2222_3333_4444; req_cmp = 64'h0;
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0;
    chk("R9 load ignored", line_o, mdl_flat());
    chk("R6 mismatch no write", 128'(wrote), 128'(0));

    // Sweep over offsets, size codes, kinds and compare outcomes
    for (int off = 0; off < LB; off++) begin
      rng = next_rand(rng); load_slot(0, rng);
      rng = next_rand(rng); load_slot(1, rng);
      for (int size = 0; size < 16; size++)
        for (int c = 0; c < 2; c++)
          for (int m = 0; m < 2; m++)
            do_req(c[0], off, size, m[0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule